// File: doc/BRIEF.md
# Lockable GPIO Port Controller

A sixteen-pin general-purpose I/O port behind a small memory-mapped register bus. Each pin owns a 4-bit configuration field. The field selects whether the pin is an input or an output, the output speed grade, and the output type. An output can be push-pull or open-drain. It takes its level either from the port's output latch or from an alternate peripheral line, such as a serial transmitter. Software samples all pin levels at once through a synchronized input register. It writes all outputs at once through the output latch.

Software can also set or clear single output bits without a read-modify-write. One register sets bits from its low half and clears bits from its high half. A second register only clears. A lock register can freeze the configuration of selected pins. The freeze takes effect only after a fixed key sequence has been written and read. Once in force, it holds until reset, so errant software cannot reconfigure pins that hardware depends on.

The bus is single-cycle. A write takes effect at the clock edge where `sel_i` and `wr_i` are high. Read data is combinational from the addressed register.

Top module: `lkio_port`

## Requirements
- R1: After reset every configuration field reads 4'h4 (floating input), the output latch reads 0, the lock is inactive, and every pad output enable is 0.
- R2: Word index 0 holds the fields of pins 0–7 and word index 1 holds the fields of pins 8–15. Pin p of a word sits at bits 4(p mod 8)+3 down to 4(p mod 8). Written values read back unchanged.
- R3: Word index 2 returns the pin levels in bits 15:0 and zeros above. A pin change becomes visible two clock edges after it is applied, through a two-flop synchronizer.
- R4: Word index 3 writes and reads the whole output latch in bits 15:0. Without a write to index 3, 4 or 5, the latch keeps its value.
- R5: A write to word index 4 sets the latch bits given by 1s in bits 15:0 and clears those given by 1s in bits 31:16. Where both halves name the same bit, the bit is set. Zero bits change nothing. The register reads as 0.
- R6: A write to word index 5 clears the latch bits given by 1s in bits 15:0. Bits 31:16 are ignored. The register reads as 0.
- R7: Field bits [1:0] are the mode: 00 means input with output enable 0, and 01/10/11 mean output at a speed grade. `pad_speed_o` bits 2p+1:2p report the mode of pin p.
- R8: Field bits [3:2] = 00 is general push-pull: the output enable is 1 and the pad drives the latch bit.
- R9: Field bits [3:2] = 10 is alternate push-pull: the output enable is 1 and the pad drives `alt_out_i` of that pin instead of the latch bit.
- R10: Field bit [2] = 1 on an output pin means open-drain, with the source being the latch (kind 01) or the alternate line (kind 11). The pad value is 0, and the output enable is 1 only while the source is 0.
- R11: The lock (word index 6) becomes active only after this exact series of accesses to index 6: a write with bit 16 = 1, a write with bit 16 = 0, a write with bit 16 = 1, a read, and a read. All three writes must carry the same bits 15:0. Any other access to index 6 in between leaves the lock inactive. While the lock is active, configuration fields of pins whose mask bit is 1 ignore writes.
- R12: Once active, the lock (read back as bit 16 = 1 with the mask in bits 15:0) and its mask hold until reset. Later writes to index 6 do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| pin_i | input | 16 | Pad input levels |
| alt_out_i | input | 16 | Alternate peripheral output per pin |
| pad_out_o | output | 16 | Pad output value |
| pad_oe_o | output | 16 | Pad output enable |
| pad_speed_o | output | 32 | Per-pin output speed grade (mode bits) |

## Verification
The bench builds the port with its default sixteen pins and a two-stage synchronizer. At this size, every configuration word and both halves of the set/clear register are real fields, with no padding. The synchronizer depth gives an observable two-edge delay on the input register. A vector table drives pin 0 through every output type with both source levels. It confirms the pad value, the enable and the speed grade. Directed tests then cover set/clear priority, a broken and a correct lock key sequence, per-pin freezing across both configuration words, and the persistence of an active lock.

// File: rtl/lkio_pkg.sv
`timescale 1ns/1ps
package lkio_pkg;
  localparam int unsigned FIELD_W = 4;

  typedef enum logic [2:0] {
    REG_CFG_LO = 3'd0,
    REG_CFG_HI = 3'd1,
    REG_IN     = 3'd2,
    REG_OUT    = 3'd3,
    REG_SETCLR = 3'd4,
    REG_CLR    = 3'd5,
    REG_LOCK   = 3'd6
  } reg_sel_e;

  // [3:2] kind: 00 gp push-pull, 01 gp open-drain, 10 alt push-pull, 11 alt open-drain
  // [1:0] mode: 00 input, else output speed grade
  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] mode;
  } pin_cfg_t;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ONE,
    LK_ZERO,
    LK_ARMED,
    LK_READ1,
    LK_ACTIVE
  } lk_state_e;
endpackage

// File: rtl/lkio_sync.sv
`timescale 1ns/1ps
module lkio_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lkio_lock.sv
`timescale 1ns/1ps
module lkio_lock
  import lkio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_stb_i,
  input  logic                rd_stb_i,
  input  logic                key_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic                active_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] pend_o
);
  lk_state_e           st_q, st_d;
  logic [NUM_PINS-1:0] pend_q, mask_q;
  logic                same_mask;

  assign same_mask = (mask_i == pend_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LK_IDLE:   if (wr_stb_i && key_i) st_d = LK_ONE;
      LK_ONE: begin
        if (wr_stb_i && !key_i && same_mask) st_d = LK_ZERO;
        else if (wr_stb_i || rd_stb_i)        st_d = LK_IDLE;
      end
      LK_ZERO: begin
        if (wr_stb_i && key_i && same_mask)  st_d = LK_ARMED;
        else if (wr_stb_i || rd_stb_i)        st_d = LK_IDLE;
      end
      LK_ARMED: begin
        if (rd_stb_i)      st_d = LK_READ1;
        else if (wr_stb_i) st_d = LK_IDLE;
      end
      LK_READ1: begin
        if (rd_stb_i)      st_d = LK_ACTIVE;
        else if (wr_stb_i) st_d = LK_IDLE;
      end
      LK_ACTIVE: st_d = LK_ACTIVE;
      default:   st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LK_IDLE;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q != LK_ACTIVE && wr_stb_i) pend_q <= mask_i;
      if (st_q == LK_READ1 && st_d == LK_ACTIVE) mask_q <= pend_q;
    end
  end

  assign active_o = (st_q == LK_ACTIVE);
  assign mask_o   = mask_q;
  assign pend_o   = pend_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> (active_o && $stable(mask_o))) else $error("lock dropped"); // R12
  AST_LOCK_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(rd_stb_i)) else $error("lock without read"); // R11
  AST_LOCK_IDLE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (mask_o == '0)) else $error("mask before lock"); // R11
endmodule

// File: rtl/lkio_pad_mux.sv
`timescale 1ns/1ps
module lkio_pad_mux
  import lkio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PINS*FIELD_W-1:0] cfg_i,
  input  logic [NUM_PINS-1:0]         odr_i,
  input  logic [NUM_PINS-1:0]         alt_i,
  output logic [NUM_PINS-1:0]         out_o,
  output logic [NUM_PINS-1:0]         oe_o,
  output logic [2*NUM_PINS-1:0]       speed_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_cfg_t c;
    logic     is_out, src, o_l, oe_l;

    assign c      = cfg_i[FIELD_W*p +: FIELD_W];
    assign is_out = (c.mode != 2'b00);
    assign src    = c.kind[1] ? alt_i[p] : odr_i[p];

    always_comb begin
      if (!is_out) begin
        o_l  = 1'b0;
        oe_l = 1'b0;
      end else if (c.kind[0]) begin
        o_l  = 1'b0;
        oe_l = ~src;
      end else begin
        o_l  = src;
        oe_l = 1'b1;
      end
    end

    assign out_o[p]         = o_l;
    assign oe_o[p]          = oe_l;
    assign speed_o[2*p +: 2] = c.mode;

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[FIELD_W*p +: 2] == 2'b00) |-> !oe_o[p]) else $error("input driven"); // R7
    AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[FIELD_W*p+2] && cfg_i[FIELD_W*p +: 2] != 2'b00) |-> !out_o[p])
      else $error("open-drain high"); // R10
    AST_PP_ALWAYS_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_i[FIELD_W*p+2] && cfg_i[FIELD_W*p +: 2] != 2'b00) |-> oe_o[p])
      else $error("push-pull released"); // R8
  end
endmodule

// File: rtl/lkio_port.sv
`timescale 1ns/1ps
module lkio_port
  import lkio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_i,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [NUM_PINS-1:0]   alt_out_i,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [2*NUM_PINS-1:0] pad_speed_o
);
  localparam int unsigned CFG_W     = NUM_PINS * FIELD_W;
  localparam int unsigned HALF_PINS = DATA_W / FIELD_W;
  localparam int unsigned KEY_BIT   = NUM_PINS;
  localparam logic [FIELD_W-1:0] CFG_RST = 4'h4;

  logic [CFG_W-1:0]    cfg_q, lock_x;
  logic [NUM_PINS-1:0] odr_q, idr, lock_mask, lock_pend;
  logic                lock_active;
  logic                wr_cfg_lo, wr_cfg_hi, wr_out, wr_setclr, wr_clr, wr_lock, rd_lock;
  logic [NUM_PINS-1:0] set_bits, clr_bits;

  assign wr_cfg_lo = sel_i && wr_i  && (addr_i == REG_CFG_LO);
  assign wr_cfg_hi = sel_i && wr_i  && (addr_i == REG_CFG_HI);
  assign wr_out    = sel_i && wr_i  && (addr_i == REG_OUT);
  assign wr_setclr = sel_i && wr_i  && (addr_i == REG_SETCLR);
  assign wr_clr    = sel_i && wr_i  && (addr_i == REG_CLR);
  assign wr_lock   = sel_i && wr_i  && (addr_i == REG_LOCK);
  assign rd_lock   = sel_i && !wr_i && (addr_i == REG_LOCK);

  assign set_bits = wdata_i[NUM_PINS-1:0];
  assign clr_bits = wdata_i[2*NUM_PINS-1:NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lockx
    assign lock_x[FIELD_W*p +: FIELD_W] = {FIELD_W{lock_mask[p]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= {NUM_PINS{CFG_RST}};
    end else if (wr_cfg_lo) begin
      cfg_q[DATA_W-1:0] <= (cfg_q[DATA_W-1:0] & lock_x[DATA_W-1:0])
                         | (wdata_i & ~lock_x[DATA_W-1:0]);
    end else if (wr_cfg_hi) begin
      cfg_q[CFG_W-1:DATA_W] <= (cfg_q[CFG_W-1:DATA_W] & lock_x[CFG_W-1:DATA_W])
                             | (wdata_i[CFG_W-DATA_W-1:0] & ~lock_x[CFG_W-1:DATA_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        odr_q <= '0;
    else if (wr_out)    odr_q <= wdata_i[NUM_PINS-1:0];
    else if (wr_setclr) odr_q <= (odr_q & ~clr_bits) | set_bits; // set wins
    else if (wr_clr)    odr_q <= odr_q & ~set_bits;
  end

  lkio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (idr)
  );

  lkio_lock #(.NUM_PINS(NUM_PINS)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_stb_i(wr_lock),
    .rd_stb_i(rd_lock),
    .key_i   (wdata_i[KEY_BIT]),
    .mask_i  (wdata_i[NUM_PINS-1:0]),
    .active_o(lock_active),
    .mask_o  (lock_mask),
    .pend_o  (lock_pend)
  );

  lkio_pad_mux #(.NUM_PINS(NUM_PINS)) u_pad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_q),
    .odr_i  (odr_q),
    .alt_i  (alt_out_i),
    .out_o  (pad_out_o),
    .oe_o   (pad_oe_o),
    .speed_o(pad_speed_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CFG_LO: rdata_o = cfg_q[HALF_PINS*FIELD_W-1:0];
      REG_CFG_HI: rdata_o = cfg_q[CFG_W-1:DATA_W];
      REG_IN:     rdata_o[NUM_PINS-1:0] = idr;
      REG_OUT:    rdata_o[NUM_PINS-1:0] = odr_q;
      REG_LOCK: begin
        rdata_o[KEY_BIT]        = lock_active;
        rdata_o[NUM_PINS-1:0]   = lock_active ? lock_mask : lock_pend;
      end
      default:    rdata_o = '0;
    endcase
  end

  AST_CFG_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_active |=> ((cfg_q & lock_x) == ($past(cfg_q) & lock_x)))
    else $error("locked field changed"); // R11
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_setclr |=> ((odr_q & $past(set_bits)) == $past(set_bits)))
    else $error("set lost"); // R5
  AST_CLR_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((odr_q & $past(set_bits)) == '0))
    else $error("clear lost"); // R6
  AST_ODR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_out || wr_setclr || wr_clr) |=> $stable(odr_q))
    else $error("latch changed"); // R4
endmodule

// File: tb/lkio_port_tb.sv
`timescale 1ns/1ps
module lkio_port_tb;
  localparam int unsigned NP = 16;
  localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_IN = 3'd2, A_OUT = 3'd3,
                         A_SC = 3'd4, A_CLR = 3'd5, A_LK = 3'd6;

  logic          clk_i = 1'b0, rst_ni = 1'b0, sel_i = 1'b0, wr_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0, rdata_o;
  logic [NP-1:0] pin_i = '0, alt_out_i = '0, pad_out_o, pad_oe_o;
  logic [31:0]   pad_speed_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  lkio_port u_dut (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .pin_i, .alt_out_i, .pad_out_o, .pad_oe_o, .pad_speed_o
  );

  // {cfg[3:0], odr, alt, exp_oe, exp_out}
  localparam logic [7:0] VEC [10] = '{
    {4'h4, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'h1, 1'b1, 1'b0, 1'b1, 1'b1},
    {4'h2, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'h5, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'h5, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'h9, 1'b0, 1'b1, 1'b1, 1'b1},
    {4'hB, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'hD, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'hE, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'h8, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    sel_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    #1 chk("R1 oe", {16'h0, pad_oe_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    bus_rd(A_CLO, rd); chk("R1 cfg_lo", rd, 32'h4444_4444);
    bus_rd(A_CHI, rd); chk("R1 cfg_hi", rd, 32'h4444_4444);
    bus_rd(A_OUT, rd); chk("R1 odr", rd, 32'h0);
    bus_rd(A_LK, rd);  chk("R1 lock", rd, 32'h0);

    // R7 R8 R9 R10 vector walk on pin 0
    foreach (VEC[i]) begin
      bus_wr(A_CLO, {28'h4444444, VEC[i][7:4]});
      bus_wr(A_OUT, {31'h0, VEC[i][3]});
      alt_out_i[0] = VEC[i][2];
      #1;
      chk($sformatf("R8_R9_R10 oe v%0d", i), {31'h0, pad_oe_o[0]}, {31'h0, VEC[i][1]});
      chk($sformatf("R8_R9_R10 out v%0d", i), {31'h0, pad_out_o[0]}, {31'h0, VEC[i][0]});
      chk($sformatf("R7 speed v%0d", i), {30'h0, pad_speed_o[1:0]}, {30'h0, VEC[i][5:4]});
    end
    alt_out_i = '0;

    // R2 config words
    bus_wr(A_CLO, 32'h1234_5678); bus_rd(A_CLO, rd); chk("R2 lo", rd, 32'h1234_5678);
    bus_wr(A_CHI, 32'h9ABC_DEF0); bus_rd(A_CHI, rd); chk("R2 hi", rd, 32'h9ABC_DEF0);
    #1 chk("R7 speed hi pin15", {30'h0, pad_speed_o[31:30]}, {30'h0, 2'b01});

    // R3 synchronizer latency
    pin_i = 16'hA5C3;
    bus_rd(A_IN, rd); chk("R3 edge0", rd, 32'h0);
    bus_rd(A_IN, rd); chk("R3 edge1", rd, 32'h0);
    bus_rd(A_IN, rd); chk("R3 edge2", rd, 32'h0000_A5C3);

    // R4 R5 R6 output latch
    bus_wr(A_OUT, 32'hFFFF_00FF); bus_rd(A_OUT, rd); chk("R4 odr", rd, 32'h0000_00FF);
    bus_wr(A_SC, 32'h00F0_0F00);  bus_rd(A_OUT, rd); chk("R5 set/clr", rd, 32'h0000_0F0F);
    bus_wr(A_SC, 32'h0010_0010);  bus_rd(A_OUT, rd); chk("R5 set wins", rd, 32'h0000_0F1F);
    bus_wr(A_SC, 32'h0);          bus_rd(A_OUT, rd); chk("R5 zero no effect", rd, 32'h0000_0F1F);
    bus_rd(A_SC, rd);             chk("R5 reads zero", rd, 32'h0);
    bus_wr(A_CLR, 32'hFFFF_0003); bus_rd(A_OUT, rd); chk("R6 clear", rd, 32'h0000_0F1C);
    bus_rd(A_CLR, rd);            chk("R6 reads zero", rd, 32'h0);
    bus_wr(A_CHI, 32'h0);         bus_rd(A_OUT, rd); chk("R4 hold", rd, 32'h0000_0F1C);

    // R11 broken key sequence
    bus_wr(A_CLO, 32'h2222_2222); bus_wr(A_CHI, 32'h2222_2222);
    bus_wr(A_LK, 32'h0001_0208);
    bus_wr(A_LK, 32'h0001_0208);
    bus_wr(A_LK, 32'h0000_0208);
    bus_wr(A_LK, 32'h0001_0208);
    bus_rd(A_LK, rd); bus_rd(A_LK, rd);
    bus_rd(A_LK, rd); chk("R11 bad seq inactive", {31'h0, rd[16]}, 32'h0);
    bus_wr(A_CLO, 32'h2222_7222); bus_rd(A_CLO, rd); chk("R11 unlocked writable", rd, 32'h2222_7222);
    bus_wr(A_CLO, 32'h2222_2222);
    // R11 mask mismatch
    bus_wr(A_LK, 32'h0001_0208); bus_wr(A_LK, 32'h0000_0200);
    bus_wr(A_LK, 32'h0001_0200); bus_rd(A_LK, rd); bus_rd(A_LK, rd);
    bus_rd(A_LK, rd); chk("R11 mask mismatch inactive", {31'h0, rd[16]}, 32'h0);

    // R11 correct sequence: lock pins 3 and 9
    bus_wr(A_LK, 32'h0001_0208); bus_wr(A_LK, 32'h0000_0208); bus_wr(A_LK, 32'h0001_0208);
    bus_rd(A_LK, rd); bus_rd(A_LK, rd);
    bus_rd(A_LK, rd); chk("R11 active", rd, 32'h0001_0208);
    bus_wr(A_CLO, 32'h3333_3333); bus_rd(A_CLO, rd); chk("R11 lo frozen pin3", rd, 32'h3333_2333);
    bus_wr(A_CHI, 32'h3333_3333); bus_rd(A_CHI, rd); chk("R11 hi frozen pin9", rd, 32'h3333_3323);

    // R12 persistence
    bus_wr(A_LK, 32'h0000_FFFF); bus_wr(A_LK, 32'h0001_0000);
    bus_rd(A_LK, rd); chk("R12 lock persists", rd, 32'h0001_0208);
    bus_wr(A_CLO, 32'h0); bus_rd(A_CLO, rd); chk("R12 still frozen", rd, 32'h0000_2000);

    // R1 reset clears lock
    @(negedge clk_i); rst_ni = 1'b0; @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    bus_rd(A_LK, rd); chk("R1 lock cleared", rd, 32'h0);
    bus_rd(A_CLO, rd); chk("R1 cfg after reset", rd, 32'h4444_4444);
    finish_run();
  end
endmodule